// File: doc/BRIEF.md
# Chain Configuration Host Sequencer

This block sits on the host side of a configuration path. It loads configuration bytes into a chain of programmable devices over an 8-bit asynchronous parallel bus. Bytes come from an upstream buffer as a valid/ready stream, and the stream marks the final byte with a last flag. For every byte the sequencer asserts the shared chip select and the write strobe for a fixed number of cycles. It then waits until the chain reports ready before it accepts the next byte. A build option picks the ready source. It is either one combined ready line, which is the AND of every device's ready output, or a read-strobe poll that samples bit 7 of the data bus.

The chain shares one open-drain fault line and one completion line. A fault seen while loading aborts the attempt and starts a retry. The retry can wait for the devices to release the fault line by themselves, or it can first force a timed low pulse on the configuration reset output. That choice is made at build time. The reset pulse length and the restart timeout are derived from a clock-rate parameter given in kHz, and the durations are given in microseconds, rounded up to whole cycles. Once the last byte has been written, the completion line must rise within a set number of cycles. The sequencer reports busy, done, an error flag with a 2-bit cause, and the retry count of the current attempt.

Top module: `cfg_chain_host`

## Requirements
- R1: Out of reset the configuration reset output, write strobe, read strobe and chip select are all high (inactive). The outputs s_ready_o, busy_o, done_o and err_o are low, and the retry count is 0.
- R2: A start pulse while not busy drives cfg_n_o low for exactly ceil(CLK_KHZ*RESET_US/1000) cycles, then releases it. busy_o is high from the first low cycle onward.
- R3: Once the fault line reads high, s_ready_o rises. A byte taken on s_valid_i is driven on data_o with data_oe_o high, and with sel_n_o and wr_n_o low, for STROBE_CYC cycles starting the cycle after the handshake.
- R4: After the write strobe, no byte is taken until the ready source is high. With the line source, chain_ready_i is used and rd_n_o stays high. With the poll source, rd_n_o and sel_n_o stay low and data_i[7] is used, while chain_ready_i is ignored.
- R5: A low fault line while loading (waiting for a byte, strobing, checking ready, or in the tail window) ends the attempt and increments the retry count. With automatic restart the sequencer waits for the fault line to go high with no reset pulse. Otherwise it first repeats the R2 reset pulse. Either way the stream restarts from byte 0.
- R6: After the last byte is accepted and the chain is ready, a high complete_i within TAIL_CYC cycles sets done_o on the next cycle and clears busy_o.
- R7: If complete_i stays low for TAIL_CYC cycles after the last byte, err_o is set with cause code 2.
- R8: If the fault line is still low ceil(CLK_KHZ*RESTART_US/1000) cycles after the wait for release begins, err_o is set with cause code 1.
- R9: A fault while the retry count equals MAX_RETRY sets err_o with cause code 3 and leaves the count unchanged.
- R10: Start is ignored while busy. Start from idle, done or error clears the retry count and the cause code (code 0 means no error) and begins a new attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration attempt |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Stream byte is the final one |
| s_ready_o | output | 1 | Sequencer takes a byte this cycle when valid |
| cfg_n_o | output | 1 | Chain configuration reset, active low |
| sel_n_o | output | 1 | Shared chip select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Status read strobe, active low (poll source only) |
| data_o | output | 8 | Byte driven onto the bus |
| data_oe_o | output | 1 | Bus output enable |
| data_i | input | 8 | Bus read-back; bit 7 is ready in poll mode |
| chain_ready_i | input | 1 | Combined ready line from the chain |
| fault_n_i | input | 1 | Shared fault line, low = error or device in reset |
| complete_i | input | 1 | Shared completion line |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | Chain configured |
| err_o | output | 1 | Attempt ended in error |
| err_code_o | output | 2 | Cause: 0 none, 1 restart timeout, 2 incomplete, 3 retries exhausted |
| retries_o | output | RETRY_W | Retries in the current attempt |

## Verification
The bench builds two instances with a clock rate of 1000 kHz. That gives an 8-cycle reset pulse and a 50-cycle restart timeout, so both timeouts are reached in short runs. It also uses a 3-cycle strobe, a 6-cycle tail window and a retry limit of 2, so three fault pulses are enough to exhaust the retries. One instance uses automatic restart with the combined ready line. The other forces reset pulses and polls bit 7 through the read strobe, while its ready line is driven with the opposite level to show that line is ignored. Because both instances see the same stimulus, every recovery mode and both ready sources are compared cycle by cycle against behavioural models.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CFG_LOW,
      ST_REL_WAIT,
      ST_LOAD,
      ST_STROBE,
      ST_CHECK,
      ST_TAIL,
      ST_DONE,
      ST_FAIL
   } cfgh_state_e;

   typedef enum logic [1:0] {
      ERR_NONE        = 2'd0,
      ERR_RESTART_TMO = 2'd1,
      ERR_INCOMPLETE  = 2'd2,
      ERR_RETRY_EXH   = 2'd3
   } cfgh_err_e;

   // Round a microsecond duration up to whole clock cycles.
   function automatic int unsigned us_to_cycles(input int unsigned khz, input int unsigned us);
      return (khz * us + 999) / 1000;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfgh_timer.sv
module cfgh_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] limit,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   assign expired = (cnt_q == (limit - 1'b1));

   // Counts from zero after every restart and holds once the limit is reached.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (!expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/cfgh_retry.sv
module cfgh_retry #(
   parameter int W   = 3,
   parameter int MAX = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         bump,
   output logic [W-1:0] count,
   output logic         at_max
);

   if (MAX < 0 || MAX >= (1 << W)) begin : g_bad_max
      $error("cfgh_retry: MAX does not fit in W bits");
   end

   assign at_max = (count == W'(MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (bump && !at_max) begin
         count <= count + 1'b1;
      end
   end

   assert_retry_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      count <= W'(MAX));

   assert_retry_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !clear && !at_max) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/cfgh_ready_sense.sv
module cfgh_ready_sense #(
   parameter bit POLL = 1'b0
) (
   input  logic in_check,
   input  logic line_i,
   input  logic bus7_i,
   output logic rdy_o,
   output logic rd_n_o,
   output logic poll_sel_o
);

   if (POLL) begin : g_poll
      // Status read held for the whole check phase; bit 7 carries ready.
      logic unused_line;
      assign unused_line = line_i;
      assign rdy_o       = bus7_i;
      assign rd_n_o      = !in_check;
      assign poll_sel_o  = in_check;
   end else begin : g_line
      logic unused_bus7;
      assign unused_bus7 = bus7_i;
      assign rdy_o       = line_i;
      assign rd_n_o      = 1'b1;
      assign poll_sel_o  = 1'b0;
   end

endmodule

// File: rtl/cfg_chain_host.sv
module cfg_chain_host
   import cfgh_pkg::*;
#(
   parameter int CLK_KHZ      = 100000,
   parameter int RESET_US     = 8,
   parameter int RESTART_US   = 50,
   parameter int STROBE_CYC   = 4,
   parameter int TAIL_CYC     = 64,
   parameter int RETRY_W      = 3,
   parameter int MAX_RETRY    = 3,
   parameter bit AUTO_RESTART = 1'b1,
   parameter bit POLL_READY   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               s_valid_i,
   input  logic [7:0]         s_data_i,
   input  logic               s_last_i,
   output logic               s_ready_o,
   output logic               cfg_n_o,
   output logic               sel_n_o,
   output logic               wr_n_o,
   output logic               rd_n_o,
   output logic [7:0]         data_o,
   output logic               data_oe_o,
   input  logic [7:0]         data_i,
   input  logic               chain_ready_i,
   input  logic               fault_n_i,
   input  logic               complete_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic [1:0]         err_code_o,
   output logic [RETRY_W-1:0] retries_o
);

   localparam int unsigned LOW_CYC = us_to_cycles(CLK_KHZ, RESET_US);
   localparam int unsigned TMO_CYC = us_to_cycles(CLK_KHZ, RESTART_US);
   localparam int unsigned CNT_MAX = max2(max2(LOW_CYC, TMO_CYC), max2(STROBE_CYC, TAIL_CYC));
   localparam int          TW      = $clog2(CNT_MAX + 1);
   localparam cfgh_state_e RETRY_ST = AUTO_RESTART ? ST_REL_WAIT : ST_CFG_LOW;

   if (CLK_KHZ < 1 || RESET_US < 1 || RESTART_US < 1) begin : g_bad_time
      $error("cfg_chain_host: clock rate and durations must be positive");
   end
   if (STROBE_CYC < 1 || TAIL_CYC < 1) begin : g_bad_cyc
      $error("cfg_chain_host: strobe and tail lengths must be at least one cycle");
   end
   if (RETRY_W < 1) begin : g_bad_rw
      $error("cfg_chain_host: retry counter needs at least one bit");
   end

   cfgh_state_e       state_q, state_d;
   cfgh_err_e         code_q, code_d;
   logic [7:0]        byte_q;
   logic              last_q;
   logic              take;
   logic              rt_clr, rt_bump, rt_at_max;
   logic              tmr_exp;
   logic [TW-1:0]     tmr_lim;
   logic              rdy;
   logic              poll_rd_n, poll_sel;
   logic              loading;
   logic              unused_bus_low;

   assign unused_bus_low = ^data_i[6:0];

   // ---------------------------------------------------------------- timer
   always_comb begin
      case (state_q)
         ST_CFG_LOW:  tmr_lim = TW'(LOW_CYC);
         ST_REL_WAIT: tmr_lim = TW'(TMO_CYC);
         ST_STROBE:   tmr_lim = TW'(STROBE_CYC);
         ST_TAIL:     tmr_lim = TW'(TAIL_CYC);
         default:     tmr_lim = '1;
      endcase
   end

   cfgh_timer #(.W(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (state_d != state_q),
      .limit   (tmr_lim),
      .expired (tmr_exp)
   );

   // ---------------------------------------------------------------- retries
   cfgh_retry #(.W(RETRY_W), .MAX(MAX_RETRY)) u_retry (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (rt_clr),
      .bump   (rt_bump),
      .count  (retries_o),
      .at_max (rt_at_max)
   );

   // ---------------------------------------------------------------- ready source
   cfgh_ready_sense #(.POLL(POLL_READY)) u_ready (
      .in_check   (state_q == ST_CHECK),
      .line_i     (chain_ready_i),
      .bus7_i     (data_i[7]),
      .rdy_o      (rdy),
      .rd_n_o     (poll_rd_n),
      .poll_sel_o (poll_sel)
   );

   // ---------------------------------------------------------------- sequencer
   assign loading = (state_q == ST_LOAD) || (state_q == ST_STROBE) ||
                    (state_q == ST_CHECK) || (state_q == ST_TAIL);

   always_comb begin
      state_d = state_q;
      code_d  = code_q;
      rt_clr  = 1'b0;
      rt_bump = 1'b0;
      take    = 1'b0;
      if (loading && !fault_n_i) begin
         if (rt_at_max) begin
            state_d = ST_FAIL;
            code_d  = ERR_RETRY_EXH;
         end else begin
            rt_bump = 1'b1;
            state_d = RETRY_ST;
         end
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
               if (start_i) begin
                  state_d = ST_CFG_LOW;
                  code_d  = ERR_NONE;
                  rt_clr  = 1'b1;
               end
            end
            ST_CFG_LOW: begin
               if (tmr_exp) state_d = ST_REL_WAIT;
            end
            ST_REL_WAIT: begin
               if (fault_n_i) begin
                  state_d = ST_LOAD;
               end else if (tmr_exp) begin
                  state_d = ST_FAIL;
                  code_d  = ERR_RESTART_TMO;
               end
            end
            ST_LOAD: begin
               if (s_valid_i) begin
                  take    = 1'b1;
                  state_d = ST_STROBE;
               end
            end
            ST_STROBE: begin
               if (tmr_exp) state_d = ST_CHECK;
            end
            ST_CHECK: begin
               if (rdy) state_d = last_q ? ST_TAIL : ST_LOAD;
            end
            ST_TAIL: begin
               if (complete_i) begin
                  state_d = ST_DONE;
               end else if (tmr_exp) begin
                  state_d = ST_FAIL;
                  code_d  = ERR_INCOMPLETE;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= ERR_NONE;
         byte_q  <= '0;
         last_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
         if (take) begin
            byte_q <= s_data_i;
            last_q <= s_last_i;
         end
      end
   end

   // ---------------------------------------------------------------- outputs
   assign cfg_n_o    = (state_q != ST_CFG_LOW);
   assign s_ready_o  = (state_q == ST_LOAD);
   assign wr_n_o     = (state_q != ST_STROBE);
   assign data_oe_o  = (state_q == ST_STROBE);
   assign sel_n_o    = !((state_q == ST_STROBE) || poll_sel);
   assign rd_n_o     = poll_rd_n;
   assign data_o     = byte_q;
   assign busy_o     = !((state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL));
   assign done_o     = (state_q == ST_DONE);
   assign err_o      = (state_q == ST_FAIL);
   assign err_code_o = code_q;

   // ---------------------------------------------------------------- checks
   logic [TW:0] low_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run_q <= '0;
      end else if (cfg_n_o) begin
         low_run_q <= '0;
      end else if (low_run_q != '1) begin
         low_run_q <= low_run_q + 1'b1;
      end
   end

   assert_reset_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_n_o) |-> low_run_q >= (TW+1)'(LOW_CYC));

   assert_accept_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready_o && s_valid_i && fault_n_i) |=> (!wr_n_o && data_oe_o && !sel_n_o));

   assert_wait_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHECK && !rdy) |=> (state_q != ST_LOAD && state_q != ST_TAIL));

   assert_fault_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((s_ready_o || !wr_n_o) && !fault_n_i) |=> (wr_n_o && !s_ready_o));

   assert_done_needs_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(complete_i));

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && fault_n_i && state_q != ST_CFG_LOW) |=> cfg_n_o);

endmodule

// File: tb/cfg_chain_host_bench.sv
module cfg_chain_host_model #(
   parameter int  LOW   = 8,
   parameter int  TMO   = 50,
   parameter int  STB   = 3,
   parameter int  TAIL  = 6,
   parameter int  MAXR  = 2,
   parameter bit  AUTO  = 1'b1,
   parameter bit  POLL  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       s_valid,
   input  logic [7:0] s_data,
   input  logic       s_last,
   input  logic       line_rdy,
   input  logic       bus7,
   input  logic       fault_n,
   input  logic       complete,
   output int         phase,
   output logic       e_cfg_n,
   output logic       e_sready,
   output logic       e_wr_n,
   output logic       e_rd_n,
   output logic       e_sel_n,
   output logic       e_oe,
   output logic [7:0] e_data,
   output logic       e_busy,
   output logic       e_done,
   output logic       e_err,
   output int         e_code,
   output int         e_retries
);
   // phases: 0 idle, 1 reset pulse, 2 release wait, 3 load, 4 strobe, 5 check, 6 tail, 7 done, 8 error
   int   el;
   logic lastb;

   always @(posedge clk or negedge rst_n) begin
      int nph;
      int ncode;
      int nrt;
      if (!rst_n) begin
         phase     <= 0;
         el        <= 0;
         e_code    <= 0;
         e_retries <= 0;
         e_data    <= 8'h00;
         lastb     <= 1'b0;
      end else begin
         nph   = phase;
         ncode = e_code;
         nrt   = e_retries;
         if (phase >= 3 && phase <= 6 && !fault_n) begin
            if (e_retries == MAXR) begin
               nph = 8; ncode = 3;
            end else begin
               nrt = e_retries + 1;
               nph = AUTO ? 2 : 1;
            end
         end else if (phase == 0 || phase == 7 || phase == 8) begin
            if (start) begin nph = 1; ncode = 0; nrt = 0; end
         end else if (phase == 1) begin
            if (el == LOW - 1) nph = 2;
         end else if (phase == 2) begin
            if (fault_n) nph = 3;
            else if (el == TMO - 1) begin nph = 8; ncode = 1; end
         end else if (phase == 3) begin
            if (s_valid) begin
               nph = 4;
               e_data <= s_data;
               lastb  <= s_last;
            end
         end else if (phase == 4) begin
            if (el == STB - 1) nph = 5;
         end else if (phase == 5) begin
            if (POLL ? bus7 : line_rdy) nph = lastb ? 6 : 3;
         end else if (phase == 6) begin
            if (complete) nph = 7;
            else if (el == TAIL - 1) begin nph = 8; ncode = 2; end
         end
         el        <= (nph != phase) ? 0 : el + 1;
         phase     <= nph;
         e_code    <= ncode;
         e_retries <= nrt;
      end
   end

   assign e_cfg_n  = (phase != 1);
   assign e_sready = (phase == 3);
   assign e_wr_n   = (phase != 4);
   assign e_oe     = (phase == 4);
   assign e_rd_n   = !(POLL && phase == 5);
   assign e_sel_n  = !(phase == 4 || (POLL && phase == 5));
   assign e_busy   = (phase >= 1 && phase <= 6);
   assign e_done   = (phase == 7);
   assign e_err    = (phase == 8);
endmodule

module cfg_chain_host_bench;
   localparam int KHZ  = 1000;
   localparam int LOW  = (KHZ * 8 + 999) / 1000;
   localparam int TMO  = (KHZ * 50 + 999) / 1000;
   localparam int STB  = 3;
   localparam int TAIL = 6;
   localparam int MAXR = 2;
   localparam int NB   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   logic start = 1'b0;
   logic fault_n = 1'b1;
   logic cmp_en = 1'b0;
   logic dev_ready, s_valid;
   int   idx_a = 0, idx_b = 0;

   always @(posedge clk) cyc <= cyc + 1;
   assign dev_ready = (cyc % 7) < 4;
   assign s_valid   = (cyc % 3) != 1;

   // DUT A outputs
   logic a_sready, a_cfg_n, a_sel_n, a_wr_n, a_rd_n, a_oe, a_busy, a_done, a_err;
   logic [7:0] a_data;
   logic [1:0] a_code, a_rt;
   // DUT B outputs
   logic b_sready, b_cfg_n, b_sel_n, b_wr_n, b_rd_n, b_oe, b_busy, b_done, b_err;
   logic [7:0] b_data;
   logic [1:0] b_code, b_rt;
   // model outputs
   int pa, pb, ca, cb, ra, rb;
   logic ea_cfg_n, ea_sr, ea_wr_n, ea_rd_n, ea_sel_n, ea_oe, ea_busy, ea_done, ea_err;
   logic eb_cfg_n, eb_sr, eb_wr_n, eb_rd_n, eb_sel_n, eb_oe, eb_busy, eb_done, eb_err;
   logic [7:0] ea_data, eb_data;

   logic [7:0] sd_a, sd_b;
   logic sl_a, sl_b, cmp_a, cmp_b;
   assign sd_a  = 8'(8'hA0 + idx_a);
   assign sd_b  = 8'(8'hA0 + idx_b);
   assign sl_a  = (idx_a == NB - 1);
   assign sl_b  = (idx_b == NB - 1);
   assign cmp_a = cmp_en && (pa == 6) && dev_ready;
   assign cmp_b = cmp_en && (pb == 6) && dev_ready;

   // Upstream buffer: replays from byte 0 whenever the chain is being reset.
   always @(posedge clk) begin
      if (pa == 1 || pa == 2) idx_a <= 0;
      else if (ea_sr && s_valid) idx_a <= idx_a + 1;
      if (pb == 1 || pb == 2) idx_b <= 0;
      else if (eb_sr && s_valid) idx_b <= idx_b + 1;
   end

   cfg_chain_host #(.CLK_KHZ(KHZ), .RESET_US(8), .RESTART_US(50), .STROBE_CYC(STB),
      .TAIL_CYC(TAIL), .RETRY_W(2), .MAX_RETRY(MAXR), .AUTO_RESTART(1'b1), .POLL_READY(1'b0))
   u_cfg_chain_host (
      .clk(clk), .rst_n(rst_n), .start_i(start), .s_valid_i(s_valid), .s_data_i(sd_a),
      .s_last_i(sl_a), .s_ready_o(a_sready), .cfg_n_o(a_cfg_n), .sel_n_o(a_sel_n),
      .wr_n_o(a_wr_n), .rd_n_o(a_rd_n), .data_o(a_data), .data_oe_o(a_oe),
      .data_i({dev_ready, 7'h2A}), .chain_ready_i(dev_ready), .fault_n_i(fault_n),
      .complete_i(cmp_a), .busy_o(a_busy), .done_o(a_done), .err_o(a_err),
      .err_code_o(a_code), .retries_o(a_rt));

   cfg_chain_host #(.CLK_KHZ(KHZ), .RESET_US(8), .RESTART_US(50), .STROBE_CYC(STB),
      .TAIL_CYC(TAIL), .RETRY_W(2), .MAX_RETRY(MAXR), .AUTO_RESTART(1'b0), .POLL_READY(1'b1))
   u_cfg_chain_host_b (
      .clk(clk), .rst_n(rst_n), .start_i(start), .s_valid_i(s_valid), .s_data_i(sd_b),
      .s_last_i(sl_b), .s_ready_o(b_sready), .cfg_n_o(b_cfg_n), .sel_n_o(b_sel_n),
      .wr_n_o(b_wr_n), .rd_n_o(b_rd_n), .data_o(b_data), .data_oe_o(b_oe),
      .data_i({dev_ready, 7'h15}), .chain_ready_i(~dev_ready), .fault_n_i(fault_n),
      .complete_i(cmp_b), .busy_o(b_busy), .done_o(b_done), .err_o(b_err),
      .err_code_o(b_code), .retries_o(b_rt));

   cfg_chain_host_model #(.LOW(LOW), .TMO(TMO), .STB(STB), .TAIL(TAIL), .MAXR(MAXR),
      .AUTO(1'b1), .POLL(1'b0)) m_a (
      .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_data(sd_a),
      .s_last(sl_a), .line_rdy(dev_ready), .bus7(dev_ready), .fault_n(fault_n),
      .complete(cmp_a), .phase(pa), .e_cfg_n(ea_cfg_n), .e_sready(ea_sr),
      .e_wr_n(ea_wr_n), .e_rd_n(ea_rd_n), .e_sel_n(ea_sel_n), .e_oe(ea_oe),
      .e_data(ea_data), .e_busy(ea_busy), .e_done(ea_done), .e_err(ea_err),
      .e_code(ca), .e_retries(ra));

   cfg_chain_host_model #(.LOW(LOW), .TMO(TMO), .STB(STB), .TAIL(TAIL), .MAXR(MAXR),
      .AUTO(1'b0), .POLL(1'b1)) m_b (
      .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_data(sd_b),
      .s_last(sl_b), .line_rdy(~dev_ready), .bus7(dev_ready), .fault_n(fault_n),
      .complete(cmp_b), .phase(pb), .e_cfg_n(eb_cfg_n), .e_sready(eb_sr),
      .e_wr_n(eb_wr_n), .e_rd_n(eb_rd_n), .e_sel_n(eb_sel_n), .e_oe(eb_oe),
      .e_data(eb_data), .e_busy(eb_busy), .e_done(eb_done), .e_err(eb_err),
      .e_code(cb), .e_retries(rb));

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic string code_tag(input int c);
      case (c)
         1:       return "R8";
         2:       return "R7";
         3:       return "R9";
         default: return "R10";
      endcase
   endfunction

   // Cycle-by-cycle comparison against the models, away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", "A cfg_n", a_cfg_n, ea_cfg_n);
         chk("R3", "A wr_n", a_wr_n, ea_wr_n);
         chk("R3", "A sel_n", a_sel_n, ea_sel_n);
         chk("R3", "A oe", a_oe, ea_oe);
         chk("R3", "A data", a_data, ea_data);
         chk("R4", "A s_ready", a_sready, ea_sr);
         chk("R4", "A rd_n", a_rd_n, ea_rd_n);
         chk("R5", "A retries", a_rt, ra);
         chk("R6", "A done", a_done, ea_done);
         chk("R10", "A busy", a_busy, ea_busy);
         chk(code_tag(ca), "A err", a_err, ea_err);
         chk(code_tag(ca), "A code", a_code, ca);
         chk("R2", "B cfg_n", b_cfg_n, eb_cfg_n);
         chk("R3", "B wr_n", b_wr_n, eb_wr_n);
         chk("R3", "B sel_n", b_sel_n, eb_sel_n);
         chk("R3", "B oe", b_oe, eb_oe);
         chk("R3", "B data", b_data, eb_data);
         chk("R4", "B s_ready", b_sready, eb_sr);
         chk("R4", "B rd_n", b_rd_n, eb_rd_n);
         chk("R5", "B retries", b_rt, rb);
         chk("R6", "B done", b_done, eb_done);
         chk("R10", "B busy", b_busy, eb_busy);
         chk(code_tag(cb), "B err", b_err, eb_err);
         chk(code_tag(cb), "B code", b_code, cb);
      end
   end

   always @(posedge clk) begin
      if (cyc == 150000) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (ea_busy || eb_busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "cfg_n", a_cfg_n, 1);
      chk("R1", "wr_n", a_wr_n, 1);
      chk("R1", "rd_n", b_rd_n, 1);
      chk("R1", "sel_n", b_sel_n, 1);
      chk("R1", "s_ready", a_sready, 0);
      chk("R1", "busy", a_busy, 0);
      chk("R1", "done", a_done, 0);
      chk("R1", "err", b_err, 0);
      chk("R1", "retries", b_rt, 0);
      repeat (2) @(negedge clk);

      // T1: full load to completion, start while busy ignored (R2, R6, R10)
      cmp_en = 1'b1;
      begin
         int lo;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         lo = !a_cfg_n ? 1 : 0;
         repeat (12) begin
            @(negedge clk);
            if (!a_cfg_n) lo++;
         end
         chk("R2", "reset pulse length", lo, LOW);
      end
      repeat (8) @(negedge clk);
      pulse_start();
      wait_idle();
      chk("R6", "A done", a_done, 1);
      chk("R6", "B done", b_done, 1);
      chk("R10", "A retries after clean run", a_rt, 0);

      // T2: completion never arrives (R7)
      cmp_en = 1'b0;
      pulse_start();
      wait_idle();
      chk("R7", "A code", a_code, 2);
      chk("R7", "B code", b_code, 2);

      // T3: one fault while loading, then success (R5)
      cmp_en = 1'b1;
      pulse_start();
      while (!(pa == 3 && idx_a >= 2)) @(negedge clk);
      fault_n = 1'b0;
      repeat (10) @(negedge clk);
      fault_n = 1'b1;
      wait_idle();
      chk("R5", "A retries", a_rt, 1);
      chk("R5", "B retries", b_rt, 1);
      chk("R6", "A done after retry", a_done, 1);
      chk("R6", "B done after retry", b_done, 1);

      // T4: fault line never released (R8)
      fault_n = 1'b0;
      pulse_start();
      wait_idle();
      chk("R8", "A code", a_code, 1);
      chk("R8", "B code", b_code, 1);
      fault_n = 1'b1;
      repeat (2) @(negedge clk);

      // T5: repeated faults exhaust the retry budget (R9)
      cmp_en = 1'b0;
      pulse_start();
      for (int k = 0; k < 3; k++) begin
         while (!(pa >= 3 && pa <= 6 && pb >= 3 && pb <= 6)) @(negedge clk);
         fault_n = 1'b0;
         repeat (2) @(negedge clk);
         fault_n = 1'b1;
      end
      wait_idle();
      chk("R9", "A code", a_code, 3);
      chk("R9", "B code", b_code, 3);
      chk("R9", "A retries held", a_rt, MAXR);
      chk("R9", "B retries held", b_rt, MAXR);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule